// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial clock of a SPI shift engine from the module clock. A single configuration word holds two divide fields and a mode bit. In linear mode the serial clock runs at the module clock divided by an even ratio. In power-of-two mode it runs at the module clock divided by a power of two. The block drives a level serial clock. Alongside it come one-cycle strobes that mark the leading edge (leaving the idle level) and the trailing edge (returning to it). The shift engine picks its sample and launch edges from these strobes according to its clock phase setting.

The divider runs only while the transfer-active input is high. While idle, the serial clock rests at the polarity level and the half-period counter stays cleared. A configuration word written during a transfer is held in a staging register and reaches the running divider only once the transfer ends. A period is therefore never cut short.

Top module: `sclk_rate_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `sclk`, `leadStb` and `trailStb` are all 0. The configuration word resets to all zeros, which is power-of-two mode with exponent 0.
- R2: In linear mode, the half-period is N+1 module clocks. N is the 8-bit field in configuration bits 7:0. The full period is 2*(N+1) module clocks.
- R3: In power-of-two mode, the half-period is 2^E module clocks. E is the 4-bit field in configuration bits 11:8. The full period is 2^(E+1) module clocks.
- R4: Configuration bit 12 selects the mode: 1 selects linear mode and 0 selects power-of-two mode. The field of the mode not selected has no effect on timing.
- R5: While `xferActive` is low, `sclk` equals `cpol` (one cycle after either changes) and no strobe is raised.
- R6: The first toggle of `sclk` happens at the h-th rising clock edge at which `xferActive` is high, where h is the half-period. Each later toggle follows every h edges, which gives a 50% duty cycle.
- R7: Each toggle raises exactly one strobe for one cycle, in the same cycle in which `sclk` takes its new level. `leadStb` is raised when `sclk` moves away from `cpol`, and `trailStb` is raised when it moves back to `cpol`.
- R8: A configuration write while `xferActive` is high does not change the running half-period. The written value takes effect for the next transfer.
- R9: When `xferActive` drops, `sclk` returns to `cpol` at the next edge with no strobe, even in the middle of a half-period. The next transfer counts its first half-period from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Write strobe for the configuration word |
| cfgData | input | 13 | Configuration word: bit 12 mode, bits 11:8 exponent, bits 7:0 linear count |
| xferActive | input | 1 | High while a transfer runs |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock level |
| leadStb | output | 1 | One-cycle strobe on a leading edge |
| trailStb | output | 1 | One-cycle strobe on a trailing edge |

## Verification
The hardest situation to reach from the ports is a configuration write that lands in the middle of a running transfer. Here the staged value must stay out of the live divider until idle, and then take hold for the following transfer. The bench writes a new linear count part way through a half-period and checks every cycle against the old period. It then checks the next transfer against the new period. A second hard case is an abort while `sclk` sits at its active level: the bench drops `xferActive` mid half-period, expects an immediate return to `cpol` with no strobe, and then checks that the restart counts from zero. The longest power-of-two setting is run for two full half-periods to cover the widest count.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

  // Strobes passed from the control half to the edge datapath.
  typedef struct packed {
    logic run;     // transfer active, divider counting
    logic toggle;  // current half-period ends at this edge
  } divStrobe_t;

  // Counter width: wide enough for the larger of the two half-periods.
  function automatic int cntWidth(input int linW, input int powW);
    int linNeed;
    int powNeed;
    linNeed = linW + 1;
    powNeed = (1 << powW);
    return (linNeed > powNeed) ? linNeed : powNeed;
  endfunction

endpackage

// File: rtl/sclkdiv_halfsel.sv
module sclkdiv_halfsel #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int CNT_W = sclkdiv_pkg::cntWidth(LIN_W, POW_W),
  localparam int CFG_W = LIN_W + POW_W + 1
) (
  input  logic [CFG_W-1:0] cfgLive,
  output logic [CNT_W-1:0] halfLen
);

  localparam int MODE_BIT = LIN_W + POW_W;

  logic [LIN_W-1:0] linField;
  logic [POW_W-1:0] powField;
  logic             linMode;
  logic [CNT_W-1:0] linHalf;
  logic [CNT_W-1:0] powHalf;

  assign linField = cfgLive[LIN_W-1:0];
  assign powField = cfgLive[MODE_BIT-1:LIN_W];
  assign linMode  = cfgLive[MODE_BIT];

  assign linHalf = CNT_W'(linField) + CNT_W'(1);
  assign powHalf = CNT_W'(1) << powField;

  assign halfLen = linMode ? linHalf : powHalf;

endmodule

// File: rtl/sclkdiv_ctrl.sv
module sclkdiv_ctrl
  import sclkdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int CFG_W = LIN_W + POW_W + 1,
  localparam int CNT_W = cntWidth(LIN_W, POW_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             xferActive,
  output divStrobe_t       stb
);

  logic [CFG_W-1:0] cfgStage;
  logic [CFG_W-1:0] cfgLive;
  logic [CNT_W-1:0] halfLen;
  logic [CNT_W-1:0] halfCnt;
  logic             halfEnd;

  // Staging register takes every write.
  always_ff @(posedge clk) begin
    if (!rst_n) cfgStage <= '0;
    else if (cfgWe) cfgStage <= cfgData;
  end

  // Live register follows the staged value only while idle; a write in
  // the same idle cycle is passed straight through.
  always_ff @(posedge clk) begin
    if (!rst_n) cfgLive <= '0;
    else if (!xferActive) cfgLive <= cfgWe ? cfgData : cfgStage;
  end

  sclkdiv_halfsel #(
    .LIN_W(LIN_W),
    .POW_W(POW_W),
    .CNT_W(CNT_W)
  ) u_halfsel (
    .cfgLive(cfgLive),
    .halfLen(halfLen)
  );

  assign halfEnd = (halfCnt == halfLen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)           halfCnt <= '0;
    else if (!xferActive) halfCnt <= '0;
    else if (halfEnd)     halfCnt <= '0;
    else                  halfCnt <= halfCnt + CNT_W'(1);
  end

  assign stb.run    = xferActive;
  assign stb.toggle = xferActive & halfEnd;

  // R8
  live_cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(xferActive) |-> $stable(cfgLive));

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halfCnt < halfLen);

  // R9
  cnt_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(xferActive) |-> halfCnt == '0);

endmodule

// File: rtl/sclkdiv_edge.sv
module sclkdiv_edge
  import sclkdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpol,
  input  divStrobe_t stb,
  output logic       sclk,
  output logic       leadStb,
  output logic       trailStb
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk     <= 1'b0;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else if (!stb.run) begin
      sclk     <= cpol;
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end else if (stb.toggle) begin
      sclk     <= ~sclk;
      leadStb  <= (sclk == cpol);
      trailStb <= (sclk != cpol);
    end else begin
      leadStb  <= 1'b0;
      trailStb <= 1'b0;
    end
  end

  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(leadStb && trailStb));

  // R7
  lead_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    leadStb |-> (sclk != $past(sclk)) && (sclk != $past(cpol)));

  // R7
  trail_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trailStb |-> (sclk != $past(sclk)) && (sclk == $past(cpol)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stb.run) |-> !leadStb && !trailStb && (sclk == $past(cpol)));

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclkdiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int CFG_W = LIN_W + POW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             xferActive,
  input  logic             cpol,
  output logic             sclk,
  output logic             leadStb,
  output logic             trailStb
);

  divStrobe_t divStb;

  sclkdiv_ctrl #(
    .LIN_W(LIN_W),
    .POW_W(POW_W)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .cfgWe(cfgWe),
    .cfgData(cfgData),
    .xferActive(xferActive),
    .stb(divStb)
  );

  sclkdiv_edge u_edge (
    .clk(clk),
    .rst_n(rst_n),
    .cpol(cpol),
    .stb(divStb),
    .sclk(sclk),
    .leadStb(leadStb),
    .trailStb(trailStb)
  );

  // R6
  toggle_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) && $past(divStb.run) |-> (leadStb || trailStb));

endmodule

// File: tb/sim_sclk_rate_gen.sv
module sim_sclk_rate_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [12:0] cfgData = '0;
  logic        xferActive = 1'b0;
  logic        cpol = 1'b0;
  logic        sclk, leadStb, trailStb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sclk_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgData(cfgData),
    .xferActive(xferActive), .cpol(cpol),
    .sclk(sclk), .leadStb(leadStb), .trailStb(trailStb)
  );

  function automatic logic [12:0] mkCfg(input bit lin, input int e, input int n);
    return {lin, 4'(e), 8'(n)};
  endfunction

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {sclk,lead,trail} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic writeCfg(input logic [12:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgData = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic setPol(input logic p);
    @(negedge clk);
    cpol = p;
    @(negedge clk);
    chk("R5 idle level", {sclk, leadStb, trailStb}, {p, 2'b00});
  endtask

  // Runs nCyc cycles of a transfer with half-period h and checks every cycle.
  // Optionally writes wrVal at cycle wrAt (0 = no write). Ends with an idle check.
  task automatic runXfer(input string tag, input int h, input int nCyc,
                         input int wrAt, input logic [12:0] wrVal);
    logic lvl;
    lvl = cpol;
    @(negedge clk);
    xferActive = 1'b1;
    for (int k = 1; k <= nCyc; k++) begin
      logic expLead, expTrail;
      @(negedge clk);
      cfgWe = 1'b0;
      expLead = 1'b0; expTrail = 1'b0;
      if (k % h == 0) begin
        lvl = ~lvl;
        expLead  = (lvl != cpol);
        expTrail = (lvl == cpol);
      end
      chk(tag, {sclk, leadStb, trailStb}, {lvl, expLead, expTrail});
      if (k == wrAt) begin
        cfgWe = 1'b1; cfgData = wrVal;
      end
    end
    xferActive = 1'b0;
    cfgWe = 1'b0;
    @(negedge clk);
    chk({tag, " R9 stop"}, {sclk, leadStb, trailStb}, {cpol, 2'b00});
  endtask

  task automatic testReset();
    chk("R1 in reset", {sclk, leadStb, trailStb}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {sclk, leadStb, trailStb}, 3'b000);
    // reset config is power-of-two, exponent 0 -> half-period 1
    runXfer("R1 default cfg", 1, 4, 0, '0);
  endtask

  task automatic testLinear();
    writeCfg(mkCfg(1, 0, 0));   runXfer("R2 lin n=0", 1, 6, 0, '0);
    writeCfg(mkCfg(1, 0, 3));   runXfer("R2 lin n=3", 4, 16, 0, '0);
    writeCfg(mkCfg(1, 0, 255)); runXfer("R2 lin n=255", 256, 1024, 0, '0);
  endtask

  task automatic testPow();
    writeCfg(mkCfg(0, 0, 0));  runXfer("R3 pow e=0", 1, 6, 0, '0);
    writeCfg(mkCfg(0, 3, 0));  runXfer("R3 pow e=3", 8, 32, 0, '0);
    writeCfg(mkCfg(0, 15, 0)); runXfer("R3 pow e=15", 32768, 65536, 0, '0);
  endtask

  task automatic testModeSel();
    writeCfg(mkCfg(1, 7, 2));   runXfer("R4 lin ignores exp", 3, 12, 0, '0);
    writeCfg(mkCfg(0, 2, 200)); runXfer("R4 pow ignores count", 4, 16, 0, '0);
  endtask

  task automatic testPolarity();
    setPol(1'b1);
    writeCfg(mkCfg(1, 0, 1));
    runXfer("R7 cpol=1", 2, 12, 0, '0);
    repeat (5) begin
      @(negedge clk);
      chk("R5 idle cpol=1", {sclk, leadStb, trailStb}, 3'b100);
    end
    setPol(1'b0);
  endtask

  task automatic testLateWrite();
    writeCfg(mkCfg(1, 0, 1));
    // R8: write a count of 9 part way through; period must stay at 2
    runXfer("R8 running period", 2, 14, 5, mkCfg(1, 0, 9));
    runXfer("R8 new period", 10, 40, 0, '0);
  endtask

  task automatic testAbort();
    writeCfg(mkCfg(1, 0, 2));
    // stop with sclk away from cpol, two cycles into the second half
    runXfer("R9 abort", 3, 5, 0, '0);
    repeat (3) begin
      @(negedge clk);
      chk("R9 idle after abort", {sclk, leadStb, trailStb}, 3'b000);
    end
    runXfer("R9 restart R6", 3, 12, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testLinear();
    testPow();
    testModeSel();
    testPolarity();
    testLateWrite();
    testAbort();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule